// File: doc/BRIEF.md
# Unaligned Two-Word Instruction Fetch Aligner

This block sits between an instruction-fetch stage and a word memory built as two banks: one bank holds the even word addresses and the other holds the odd ones. Every instruction is two words long. The first word is the source address and the second is the destination address. The block lets an instruction begin at any word address, even or odd. It keeps a full-width program counter, including the least significant bit. From it, the block forms the address of the source word (PC) and of the destination word (PC+1). It sends each of the two addresses to whichever bank holds it, and reads both banks in the same cycle.

Bank data returns one cycle after the read is issued. The block then crosses the two bank outputs back so that the source word always appears on one fixed port and the destination word on another. The swap is steered by the PC bit that was captured when the read was issued, not by the current PC. The fetch stage raises a request. The block answers ready when the banks grant the cycle. A fetch is accepted on a cycle with both request and ready high. After an accepted fetch, the PC moves forward by two words unless the fetch stage holds it with a stall input. A load input sets the PC to a new start address.

Top module: `ifetch_align`

## Requirements
- R1: After reset, the PC equals the RESET_PC parameter (default 0). The delivered-valid output, both bank read enables and the ready output are low until the first qualifying inputs arrive.
- R2: On an accepted fetch with PC bit 0 equal to 0, both bank indexes equal PC shifted right by one. A bank index is a word address shifted right by one bit.
- R3: On an accepted fetch with PC bit 0 equal to 1, the odd-bank index is PC shifted right by one. The even-bank index is (PC+1) shifted right by one. The sum PC+1 wraps modulo 2^ADDR_W, so PC = all-ones reads even index 0.
- R4: Ready equals bank grant while no PC load is present. Both bank read enables are high exactly in the cycles where request and ready are both high.
- R5: The delivered-valid output is high in exactly the cycle after each accepted fetch.
- R6: When delivered-valid is high and the delivered address is even, the source output carries the even bank's data and the destination output carries the odd bank's data. When that address is odd, the two are crossed. Either way, the source word is the memory word at the delivered address and the destination word is the word at that address plus one.
- R7: After an accepted fetch with the stall input low, the PC rises by 2 (modulo 2^ADDR_W). After an accepted fetch with the stall input high, or with no accepted fetch, the PC keeps its value.
- R8: A PC load writes the load value into the PC at the next edge, holds ready low in its own cycle, and takes precedence over stepping.
- R9: The delivered-address output equals the PC of the accepted fetch whose words are being delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_load | input | 1 | Load a new start address into the PC |
| pc_load_val | input | ADDR_W | Word address to load |
| ireq | input | 1 | Fetch stage requests an instruction |
| fetch_stall | input | 1 | Hold the PC after an accepted fetch |
| irdy | output | 1 | Block can accept the request this cycle |
| bank_gnt | input | 1 | Both banks are free for a read this cycle |
| ev_en | output | 1 | Even bank read enable |
| ev_idx | output | ADDR_W-1 | Even bank row index |
| od_en | output | 1 | Odd bank read enable |
| od_idx | output | ADDR_W-1 | Odd bank row index |
| ev_rdata | input | WORD_W | Even bank read data, one cycle after enable |
| od_rdata | input | WORD_W | Odd bank read data, one cycle after enable |
| ivalid | output | 1 | Source and destination words are valid |
| iaddr | output | ADDR_W | Word address of the delivered instruction |
| src_word | output | WORD_W | Source-address word (memory at iaddr) |
| dst_word | output | WORD_W | Destination-address word (memory at iaddr+1) |
| pc_out | output | ADDR_W | Current program counter |

## Verification
The assertions check the cycle-level rules on every cycle:
- the bank index relation for even and odd PCs, including the wrap;
- that the enables coincide with acceptance;
- that delivered-valid and the delivered address follow one cycle after acceptance;
- that the data crossing follows the delivered address's low bit;
- that the PC steps, holds and loads as required.

Whether the delivered words are the right memory contents can only be shown by the bench's scenarios, since that depends on an external memory that the bench models. The same holds for back-to-back streams that cross from odd to even alignment and for a stream that wraps past the top of the address space.

// File: rtl/ifa_pkg.sv
package ifa_pkg;

  // Which physical bank feeds a given output lane.
  typedef enum logic {
    LANE_EVEN = 1'b0,
    LANE_ODD  = 1'b1
  } bank_sel_e;

  // Output lane 0 is the source word, lane 1 the destination word.
  // Lane k reads address PC+k, whose parity is pc_lsb ^ k.
  function automatic bank_sel_e bank_for_lane(input logic pc_lsb, input logic lane);
    return bank_sel_e'(pc_lsb ^ lane);
  endfunction

endpackage

// File: rtl/ifa_pc_reg.sv
module ifa_pc_reg #(
  parameter int ADDR_W   = 12,
  parameter int RESET_PC = 0,
  parameter int STEP     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              advance,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(STEP);

  function automatic logic [ADDR_W-1:0] step_pc(input logic [ADDR_W-1:0] cur);
    return cur + PC_STEP;
  endfunction

  logic [ADDR_W-1:0] pc_nxt;

  always_comb begin
    pc_nxt = pc;
    if (load) begin
      pc_nxt = load_val;
    end else if (advance) begin
      pc_nxt = step_pc(pc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= PC_INIT;
    end else begin
      pc <= pc_nxt;
    end
  end

endmodule

// File: rtl/ifa_addr_route.sv
module ifa_addr_route #(
  parameter int ADDR_W = 12
) (
  input  logic              pc_lsb,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-2:0] ev_idx,
  output logic [ADDR_W-2:0] od_idx
);

  localparam int BANK_AW = ADDR_W - 1;

  function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [BANK_AW-1:0] row_of(input logic [ADDR_W-1:0] a);
    return BANK_AW'(a >> 1);
  endfunction

  logic [ADDR_W-1:0] src_a;
  logic [ADDR_W-1:0] dst_a;
  logic [ADDR_W-1:0] even_a;
  logic [ADDR_W-1:0] odd_a;

  assign src_a = pc;
  assign dst_a = next_word(pc);

  // Address-side crossing: the even-parity one of {PC, PC+1} goes to the even bank.
  always_comb begin
    if (pc_lsb) begin
      even_a = dst_a;
      odd_a  = src_a;
    end else begin
      even_a = src_a;
      odd_a  = dst_a;
    end
  end

  assign ev_idx = row_of(even_a);
  assign od_idx = row_of(odd_a);

endmodule

// File: rtl/ifa_data_route.sv
module ifa_data_route
  import ifa_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] pc,
  input  logic [WORD_W-1:0] ev_rdata,
  input  logic [WORD_W-1:0] od_rdata,
  output logic              ivalid,
  output logic [ADDR_W-1:0] iaddr,
  output logic [WORD_W-1:0] src_word,
  output logic [WORD_W-1:0] dst_word
);

  localparam int LANES = 2;

  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic              lsb_q;
  logic [WORD_W-1:0] lane_word [LANES];

  // Capture the issuing fetch's address so the return swap uses its LSB.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= fire;
      if (fire) begin
        addr_q <= pc;
      end
    end
  end

  assign lsb_q = addr_q[0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic LANE_ID = (k == 1);
    bank_sel_e sel;
    assign sel          = bank_for_lane(lsb_q, LANE_ID);
    assign lane_word[k] = (sel == LANE_ODD) ? od_rdata : ev_rdata;
  end

  assign ivalid   = vld_q;
  assign iaddr    = addr_q;
  assign src_word = lane_word[0];
  assign dst_word = lane_word[1];

endmodule

// File: rtl/ifetch_align.sv
module ifetch_align #(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_load_val,
  input  logic              ireq,
  input  logic              fetch_stall,
  output logic              irdy,
  input  logic              bank_gnt,
  output logic              ev_en,
  output logic [ADDR_W-2:0] ev_idx,
  output logic              od_en,
  output logic [ADDR_W-2:0] od_idx,
  input  logic [WORD_W-1:0] ev_rdata,
  input  logic [WORD_W-1:0] od_rdata,
  output logic              ivalid,
  output logic [ADDR_W-1:0] iaddr,
  output logic [WORD_W-1:0] src_word,
  output logic [WORD_W-1:0] dst_word,
  output logic [ADDR_W-1:0] pc_out
);

  logic              fire;
  logic              step_ok;
  logic [ADDR_W-1:0] pc;

  assign irdy    = bank_gnt & ~pc_load;
  assign fire    = ireq & irdy;
  assign step_ok = fire & ~fetch_stall;

  ifa_pc_reg #(
    .ADDR_W  (ADDR_W),
    .RESET_PC(RESET_PC),
    .STEP    (2)
  ) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pc_load),
    .load_val(pc_load_val),
    .advance (step_ok),
    .pc      (pc)
  );

  ifa_addr_route #(
    .ADDR_W(ADDR_W)
  ) u_arte (
    .pc_lsb(pc[0]),
    .pc    (pc),
    .ev_idx(ev_idx),
    .od_idx(od_idx)
  );

  assign ev_en = fire;
  assign od_en = fire;

  ifa_data_route #(
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
  ) u_drte (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .pc      (pc),
    .ev_rdata(ev_rdata),
    .od_rdata(od_rdata),
    .ivalid  (ivalid),
    .iaddr   (iaddr),
    .src_word(src_word),
    .dst_word(dst_word)
  );

  assign pc_out = pc;

endmodule

// File: rtl/ifetch_align_chk.sv
module ifetch_align_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_load_val,
  input logic              ireq,
  input logic              fetch_stall,
  input logic              irdy,
  input logic              bank_gnt,
  input logic              ev_en,
  input logic [ADDR_W-2:0] ev_idx,
  input logic              od_en,
  input logic [ADDR_W-2:0] od_idx,
  input logic [WORD_W-1:0] ev_rdata,
  input logic [WORD_W-1:0] od_rdata,
  input logic              ivalid,
  input logic [ADDR_W-1:0] iaddr,
  input logic [WORD_W-1:0] src_word,
  input logic [WORD_W-1:0] dst_word,
  input logic [ADDR_W-1:0] pc_out,
  input logic              fire
);

  assert_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irdy == (bank_gnt && !pc_load));

  assert_en_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en == (ireq && irdy)) && (od_en == ev_en));

  assert_even_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en && !pc_out[0]) |-> (ev_idx == od_idx) && (ev_idx == pc_out[ADDR_W-1:1]));

  assert_odd_rows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en && pc_out[0]) |-> (od_idx == pc_out[ADDR_W-1:1]) && (ev_idx == od_idx + 1'b1));

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ivalid);

  assert_valid_only_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !ivalid);

  assert_iaddr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> iaddr == $past(pc_out));

  assert_swap_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ivalid && !iaddr[0]) |-> (src_word == ev_rdata) && (dst_word == od_rdata));

  assert_swap_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ivalid && iaddr[0]) |-> (src_word == od_rdata) && (dst_word == ev_rdata));

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !fetch_stall && !pc_load) |=> pc_out == $past(pc_out) + ADDR_W'(2));

  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!fire || fetch_stall) && !pc_load) |=> $stable(pc_out));

  assert_pc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> pc_out == $past(pc_load_val));

endmodule

bind ifetch_align ifetch_align_chk #(
  .WORD_W(WORD_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_load    (pc_load),
  .pc_load_val(pc_load_val),
  .ireq       (ireq),
  .fetch_stall(fetch_stall),
  .irdy       (irdy),
  .bank_gnt   (bank_gnt),
  .ev_en      (ev_en),
  .ev_idx     (ev_idx),
  .od_en      (od_en),
  .od_idx     (od_idx),
  .ev_rdata   (ev_rdata),
  .od_rdata   (od_rdata),
  .ivalid     (ivalid),
  .iaddr      (iaddr),
  .src_word   (src_word),
  .dst_word   (dst_word),
  .pc_out     (pc_out),
  .fire       (fire)
);

// File: tb/ifetch_align_tb.sv
module ifetch_align_tb;

  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 12;
  localparam int BANK_AW  = ADDR_W - 1;
  localparam int CLK_PER  = 10;
  localparam int NVEC     = 8;

  // Vector: {start pc, stall, grant}
  localparam logic [ADDR_W+1:0] VEC [NVEC] = '{
    {12'h000, 1'b0, 1'b1},
    {12'h001, 1'b0, 1'b1},
    {12'h0FE, 1'b1, 1'b1},
    {12'h0FF, 1'b1, 1'b1},
    {12'hFFF, 1'b0, 1'b1},
    {12'hFFE, 1'b0, 1'b1},
    {12'h055, 1'b0, 1'b0},
    {12'h2AA, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pc_load = 1'b0;
  logic [ADDR_W-1:0] pc_load_val = '0;
  logic              ireq = 1'b0;
  logic              fetch_stall = 1'b0;
  logic              irdy;
  logic              bank_gnt = 1'b0;
  logic              ev_en, od_en;
  logic [BANK_AW-1:0] ev_idx, od_idx;
  logic [WORD_W-1:0] ev_rdata = '0;
  logic [WORD_W-1:0] od_rdata = '0;
  logic              ivalid;
  logic [ADDR_W-1:0] iaddr;
  logic [WORD_W-1:0] src_word, dst_word;
  logic [ADDR_W-1:0] pc_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  ifetch_align #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .RESET_PC(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .ireq(ireq), .fetch_stall(fetch_stall), .irdy(irdy), .bank_gnt(bank_gnt),
    .ev_en(ev_en), .ev_idx(ev_idx), .od_en(od_en), .od_idx(od_idx),
    .ev_rdata(ev_rdata), .od_rdata(od_rdata), .ivalid(ivalid), .iaddr(iaddr),
    .src_word(src_word), .dst_word(dst_word), .pc_out(pc_out)
  );

  // Memory content: a distinct word for every address.
  function automatic logic [WORD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return WORD_W'(a) * 16'd7 + 16'h1234;
  endfunction

  // Bank model, read latency one cycle.
  always @(posedge clk) begin
    if (ev_en) ev_rdata <= mem_word({ev_idx, 1'b0});
    if (od_en) od_rdata <= mem_word({od_idx, 1'b1});
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected even/odd rows for a fetch at address a.
  function automatic logic [BANK_AW-1:0] exp_even_row(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] nxt = a + 1'b1;
    return a[0] ? nxt[ADDR_W-1:1] : a[ADDR_W-1:1];
  endfunction

  function automatic logic [BANK_AW-1:0] exp_odd_row(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] nxt = a + 1'b1;
    return a[0] ? a[ADDR_W-1:1] : nxt[ADDR_W-1:1];
  endfunction

  task automatic load_pc(input logic [ADDR_W-1:0] v);
    @(negedge clk);
    pc_load = 1'b1; pc_load_val = v; ireq = 1'b1; bank_gnt = 1'b1;
    #1;
    chk("R8 irdy low during load", 32'(irdy), 32'd0);
    chk("R4 no enable during load", 32'(ev_en | od_en), 32'd0);
    @(negedge clk);
    pc_load = 1'b0; ireq = 1'b0;
    #1;
    chk("R8 pc loaded", 32'(pc_out), 32'(v));
  endtask

  task automatic check_delivery(input string tag, input logic [ADDR_W-1:0] a);
    chk({tag, " R5 ivalid"}, 32'(ivalid), 32'd1);
    chk({tag, " R9 iaddr"}, 32'(iaddr), 32'(a));
    chk({tag, " R6 src_word"}, 32'(src_word), 32'(mem_word(a)));
    chk({tag, " R6 dst_word"}, 32'(dst_word), 32'(mem_word(a + 1'b1)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] p;
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1 pc reset", 32'(pc_out), 32'd0);
    chk("R1 ivalid reset", 32'(ivalid), 32'd0);
    chk("R1 enables reset", 32'(ev_en | od_en), 32'd0);
    chk("R1 irdy reset", 32'(irdy), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [ADDR_W-1:0] vpc;
      logic vst, vg;
      {vpc, vst, vg} = VEC[i];
      load_pc(vpc);
      @(negedge clk);
      ireq = 1'b1; fetch_stall = vst; bank_gnt = vg;
      #1;
      chk("R4 irdy follows grant", 32'(irdy), 32'(vg));
      chk("R4 enable on accept", 32'(ev_en & od_en), 32'(vg));
      if (vg) begin
        chk(vpc[0] ? "R3 even row" : "R2 even row", 32'(ev_idx), 32'(exp_even_row(vpc)));
        chk(vpc[0] ? "R3 odd row" : "R2 odd row", 32'(od_idx), 32'(exp_odd_row(vpc)));
      end
      @(negedge clk);
      ireq = 1'b0; fetch_stall = 1'b0;
      #1;
      if (vg) check_delivery("vec", vpc);
      else chk("R5 no valid without accept", 32'(ivalid), 32'd0);
      p = (vg && !vst) ? vpc + 12'd2 : vpc;
      chk("R7 pc after fetch", 32'(pc_out), 32'(p));
    end

    // Back-to-back stream from an odd address
    load_pc(12'h7FD);
    p = 12'h7FD;
    @(negedge clk);
    ireq = 1'b1; bank_gnt = 1'b1; fetch_stall = 1'b0;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      #1;
      check_delivery("stream", p);
      p = p + 12'd2;
      chk("R7 stream pc", 32'(pc_out), 32'(p));
    end

    // Stall held mid-stream: same instruction re-delivered
    fetch_stall = 1'b1;
    for (int n = 0; n < 2; n++) begin
      @(negedge clk);
      #1;
      check_delivery("stall", p);
      chk("R7 stall holds pc", 32'(pc_out), 32'(p));
    end
    fetch_stall = 1'b0;

    // Grant dropped: nothing issued, pc held, no delivery next cycle
    bank_gnt = 1'b0;
    @(negedge clk);
    #1;
    chk("R4 no enable without grant", 32'(ev_en | od_en), 32'd0);
    @(negedge clk);
    #1;
    chk("R5 no valid after idle", 32'(ivalid), 32'd0);
    chk("R7 idle holds pc", 32'(pc_out), 32'(p));
    ireq = 1'b0;

    // Wrap stream across the top of the address space
    load_pc(12'hFFD);
    p = 12'hFFD;
    @(negedge clk);
    ireq = 1'b1; bank_gnt = 1'b1;
    #1;
    chk("R3 odd row near top", 32'(od_idx), 32'h7FE);
    @(negedge clk);
    #1;
    check_delivery("wrap1", p);
    chk("R3 wrap even row", 32'(ev_idx), 32'd0);
    chk("R3 wrap odd row", 32'(od_idx), 32'h7FF);
    @(negedge clk);
    ireq = 1'b0;
    #1;
    check_delivery("wrap2", 12'hFFF);
    chk("R7 pc wraps", 32'(pc_out), 32'h001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule